// File: doc/BRIEF.md
# PCI Host Bridge Window Register Bank

This block is the control-register bank of a PCI host bridge. It answers a 4 KB slave region of 32-bit word accesses. The region holds four outbound and three inbound address-translation windows and a gasket timer. The translation logic elsewhere in the bridge reads those registers. The bottom two words of the region are the configuration address and data ports. The bank does not serve these two words itself. It turns accesses to them into strobes for an external configuration engine, and it returns that engine's read value.

A separate combinational path routes slot interrupts. It takes a device number and an interrupt pin, and it gives the host interrupt line that the pin is wired to. Two slots exist, and their pins are rotated by device number. Any other device number is flagged as an error.

The bus side has no back-pressure. A read strobe or a write strobe is accepted in every cycle, and both may be high in the same cycle. The read response is a one-cycle valid pulse that cannot be stalled.

Top module: `pcihb_regbank`

## Requirements
- R1: After reset, every window register and the timer read as 0.
- R2: The four outbound windows sit at 0xC20, 0xC40, 0xC60 and 0xC80. Each has four independent 32-bit registers at +0x0 (translation), +0x4 (translation high), +0x8 (base) and +0x10 (attributes). A write to one register changes only that register, and +0x10 is kept apart from +0x0.
- R3: Outbound offset +0xC and inbound offset +0x4 are holes. A read of either returns 0, and a write to either changes no register.
- R4: The three inbound windows sit at 0xDA0, 0xDC0 and 0xDE0. Each has four independent registers at +0x0 (translation), +0x8 (base), +0xC (base high) and +0x10 (attributes).
- R5: A 32-bit gasket timer register sits at 0xE20 and can be written and read back.
- R6: A read of any offset outside R2, R4, R5, R8 and R9 returns 0, and a write there has no effect. Such offsets include 0x008, 0xC00, 0xCA0, 0xD80, 0xE24 and 0xE40, and sub-offsets +0x14 to +0x1C of a window.
- R7: A write takes effect at the clock edge that samples it, so a read in the next cycle sees the new value. The read data and bus_rvalid appear one cycle after the read strobe. bus_rvalid is low in the cycle after a cycle with no read.
- R8: A write to offset 0x0 raises cfg_addr_wr in the same cycle, with cfg_wdata equal to bus_wdata with its four bytes reversed. A read of offset 0x0 raises cfg_addr_rd in the same cycle, and one cycle later it returns cfg_rdata with its bytes reversed. This is the big-endian port.
- R9: A write to offset 0x4 raises cfg_data_wr, with cfg_wdata equal to bus_wdata unchanged. A read of offset 0x4 raises cfg_data_rd, and one cycle later it returns cfg_rdata unchanged. No config strobe is raised for any offset at or above 0x8.
- R10: For device number 0x11 or 0x12, interrupt pin n (0 to 3) routes to line (n + devno − 0x10) mod 4, with irq_bad_dev low.
- R11: For every other device number, irq_line is 0 and irq_bad_dev is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, accepted every cycle |
| bus_rd | input | 1 | Read strobe, accepted every cycle |
| bus_addr | input | 12 | Byte offset in the region (bits 1:0 ignored) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| cfg_addr_wr | output | 1 | Config address port write strobe |
| cfg_addr_rd | output | 1 | Config address port read strobe |
| cfg_data_wr | output | 1 | Config data port write strobe |
| cfg_data_rd | output | 1 | Config data port read strobe |
| cfg_wdata | output | 32 | Write data for the config engine |
| cfg_rdata | input | 32 | Read value from the config engine |
| irq_devno | input | 5 | Device number of the interrupting slot |
| irq_pin | input | 2 | Interrupt pin of that device (0 to 3) |
| irq_line | output | 2 | Host interrupt line selected |
| irq_bad_dev | output | 1 | The device number is not a known slot |

## Verification
The config strobes, cfg_wdata and the interrupt outputs are combinational. The bench checks them 1 ns after it drives the inputs, inside the same cycle. Register writes land at the next rising edge. Read data and bus_rvalid are due one cycle after the edge that samples bus_rd. Inputs change on the falling edge, and a monitor samples 1 ns after each rising edge. At that point the bus_rd it still sees is exactly the one whose answer is due, so the expected valid and the head of the scoreboard queue line up with the cycle under test.

// File: rtl/pcihb_pkg.sv
package pcihb_pkg;

  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int SLOT_W = 7;   // address bits [11:5]

  // 32-byte slot codes of the register groups
  localparam logic [SLOT_W-1:0] OUT_FIRST_SLOT = 7'h61;  // 0xC20
  localparam logic [SLOT_W-1:0] IN_FIRST_SLOT  = 7'h6D;  // 0xDA0
  localparam logic [SLOT_W-1:0] TIMER_SLOT     = 7'h71;  // 0xE20

  // outbound storage index equals address bits [7:5]; first window is 1
  localparam int OUT_IDX_BASE = 1;
  localparam int IN_IDX_BASE  = 0;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_CFG_ADDR,
    TGT_CFG_DATA,
    TGT_OUT,
    TGT_IN,
    TGT_TIMER
  } tgt_e;

  typedef struct packed {
    tgt_e       tgt;
    logic [2:0] idx;
    logic [1:0] slot;
  } dec_s;

  function automatic logic [DATA_W-1:0] swap_bytes(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] r;
    for (int b = 0; b < DATA_W/8; b++) begin
      r[8*b +: 8] = v[DATA_W-8-8*b +: 8];
    end
    return r;
  endfunction

endpackage

// File: rtl/pcihb_addr_dec.sv
module pcihb_addr_dec
  import pcihb_pkg::*;
#(
  parameter int NUM_OUT = 4,
  parameter int NUM_IN  = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output dec_s              dec
);

  localparam logic [SLOT_W-1:0] OUT_LAST_SLOT = SLOT_W'(int'(OUT_FIRST_SLOT) + NUM_OUT - 1);
  localparam logic [SLOT_W-1:0] IN_LAST_SLOT  = SLOT_W'(int'(IN_FIRST_SLOT) + NUM_IN - 1);

  logic [SLOT_W-1:0] slot7;
  logic [2:0]        sub;

  assign slot7 = addr[11:5];
  assign sub   = addr[4:2];

  always_comb begin
    dec = '{tgt: TGT_NONE, idx: 3'd0, slot: 2'd0};
    if (addr[11:3] == 9'd0) begin
      dec.tgt = addr[2] ? TGT_CFG_DATA : TGT_CFG_ADDR;
    end else if (slot7 >= OUT_FIRST_SLOT && slot7 <= OUT_LAST_SLOT) begin
      dec.idx = addr[7:5];
      dec.tgt = TGT_OUT;
      unique case (sub)
        3'd0: dec.slot = 2'd0;   // translation
        3'd1: dec.slot = 2'd1;   // translation high
        3'd2: dec.slot = 2'd2;   // base
        3'd4: dec.slot = 2'd3;   // attributes
        default: dec.tgt = TGT_NONE;
      endcase
    end else if (slot7 >= IN_FIRST_SLOT && slot7 <= IN_LAST_SLOT) begin
      dec.idx = {1'b0, addr[6:5]} - 3'd1;
      dec.tgt = TGT_IN;
      unique case (sub)
        3'd0: dec.slot = 2'd0;   // translation
        3'd2: dec.slot = 2'd1;   // base
        3'd3: dec.slot = 2'd2;   // base high
        3'd4: dec.slot = 2'd3;   // attributes
        default: dec.tgt = TGT_NONE;
      endcase
    end else if (slot7 == TIMER_SLOT && sub == 3'd0) begin
      dec.tgt = TGT_TIMER;
    end
  end

endmodule

// File: rtl/pcihb_win_bank.sv
module pcihb_win_bank
  import pcihb_pkg::*;
#(
  parameter int N_WIN    = 4,
  parameter int N_REG    = 4,
  parameter int IDX_BASE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        idx,
  input  logic [1:0]        slot,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_val
);

  localparam int N_ALL = N_WIN * N_REG;

  logic [2:0]        rel;
  logic [DATA_W-1:0] flat [N_ALL];

  assign rel = idx - 3'(IDX_BASE);

  for (genvar w = 0; w < N_WIN; w++) begin : g_win
    for (genvar r = 0; r < N_REG; r++) begin : g_reg
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          q <= '0;
        end else if (wr_en && int'(rel) == w && int'(slot) == r) begin
          q <= wdata;
        end
      end
      assign flat[w*N_REG + r] = q;
    end
  end

  always_comb begin
    rd_val = '0;
    if (int'(rel) < N_WIN && int'(slot) < N_REG) begin
      rd_val = flat[int'(rel) * N_REG + int'(slot)];
    end
  end

endmodule

// File: rtl/pcihb_irq_route.sv
module pcihb_irq_route #(
  parameter int DEV_W    = 5,
  parameter int PIN_W    = 2,
  parameter int DEV_LO   = 'h11,
  parameter int N_SLOTS  = 2,
  parameter int DEV_BIAS = 'h10
) (
  input  logic [DEV_W-1:0] devno,
  input  logic [PIN_W-1:0] pin,
  output logic [PIN_W-1:0] line,
  output logic             bad_dev
);

  localparam int SUM_W = DEV_W + 2;

  logic [SUM_W-1:0] sum;

  assign bad_dev = !(int'(devno) >= DEV_LO && int'(devno) < DEV_LO + N_SLOTS);
  assign sum     = SUM_W'(devno) + SUM_W'(pin) - SUM_W'(DEV_BIAS);
  assign line    = bad_dev ? '0 : sum[PIN_W-1:0];

endmodule

// File: rtl/pcihb_regbank.sv
module pcihb_regbank
  import pcihb_pkg::*;
#(
  parameter int NUM_OUT = 4,
  parameter int NUM_IN  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              cfg_addr_wr,
  output logic              cfg_addr_rd,
  output logic              cfg_data_wr,
  output logic              cfg_data_rd,
  output logic [DATA_W-1:0] cfg_wdata,
  input  logic [DATA_W-1:0] cfg_rdata,
  input  logic [4:0]        irq_devno,
  input  logic [1:0]        irq_pin,
  output logic [1:0]        irq_line,
  output logic              irq_bad_dev
);

  dec_s              dec;
  logic [DATA_W-1:0] out_val, in_val, tmr_val, rd_mux;

  pcihb_addr_dec #(.NUM_OUT(NUM_OUT), .NUM_IN(NUM_IN)) u_dec (
    .addr (bus_addr),
    .dec  (dec)
  );

  pcihb_win_bank #(.N_WIN(NUM_OUT), .N_REG(4), .IDX_BASE(OUT_IDX_BASE)) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (bus_wr && dec.tgt == TGT_OUT),
    .idx    (dec.idx),
    .slot   (dec.slot),
    .wdata  (bus_wdata),
    .rd_val (out_val)
  );

  pcihb_win_bank #(.N_WIN(NUM_IN), .N_REG(4), .IDX_BASE(IN_IDX_BASE)) u_in (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (bus_wr && dec.tgt == TGT_IN),
    .idx    (dec.idx),
    .slot   (dec.slot),
    .wdata  (bus_wdata),
    .rd_val (in_val)
  );

  pcihb_win_bank #(.N_WIN(1), .N_REG(1), .IDX_BASE(0)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (bus_wr && dec.tgt == TGT_TIMER),
    .idx    (dec.idx),
    .slot   (dec.slot),
    .wdata  (bus_wdata),
    .rd_val (tmr_val)
  );

  pcihb_irq_route u_irq (
    .devno   (irq_devno),
    .pin     (irq_pin),
    .line    (irq_line),
    .bad_dev (irq_bad_dev)
  );

  // config engine strobes
  assign cfg_addr_wr = bus_wr && dec.tgt == TGT_CFG_ADDR;
  assign cfg_addr_rd = bus_rd && dec.tgt == TGT_CFG_ADDR;
  assign cfg_data_wr = bus_wr && dec.tgt == TGT_CFG_DATA;
  assign cfg_data_rd = bus_rd && dec.tgt == TGT_CFG_DATA;
  assign cfg_wdata   = (dec.tgt == TGT_CFG_ADDR) ? swap_bytes(bus_wdata) : bus_wdata;

  always_comb begin
    unique case (dec.tgt)
      TGT_CFG_ADDR: rd_mux = swap_bytes(cfg_rdata);
      TGT_CFG_DATA: rd_mux = cfg_rdata;
      TGT_OUT:      rd_mux = out_val;
      TGT_IN:       rd_mux = in_val;
      TGT_TIMER:    rd_mux = tmr_val;
      default:      rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) begin
        bus_rdata <= rd_mux;
      end
    end
  end

endmodule

// File: rtl/pcihb_regbank_chk.sv
module pcihb_regbank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [11:0] bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        bus_rvalid,
  input logic        cfg_addr_wr,
  input logic        cfg_addr_rd,
  input logic        cfg_data_wr,
  input logic        cfg_data_rd,
  input logic [31:0] cfg_wdata,
  input logic [31:0] cfg_rdata,
  input logic [4:0]  irq_devno,
  input logic [1:0]  irq_pin,
  input logic [1:0]  irq_line,
  input logic        irq_bad_dev
);

  logic [31:0] wdata_rev;
  assign wdata_rev = {bus_wdata[7:0], bus_wdata[15:8], bus_wdata[23:16], bus_wdata[31:24]};

  assert_rvalid_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);

  assert_rvalid_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid);

  assert_low_region_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr[11:10] != 2'b11 && bus_addr[11:3] != 9'd0) |=> bus_rdata == 32'd0);

  assert_cfg_addr_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[11:2] == 10'd0) |-> (cfg_addr_wr && cfg_wdata == wdata_rev));

  assert_cfg_data_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[11:2] == 10'd1) |-> (cfg_data_wr && cfg_wdata == bus_wdata));

  assert_no_cfg_strobe_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[11:3] != 9'd0) |-> !(cfg_addr_wr || cfg_addr_rd || cfg_data_wr || cfg_data_rd));

  assert_timer_readback_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[11:2] == 10'h388) ##1 (bus_rd && !bus_wr && bus_addr[11:2] == 10'h388)
      |=> bus_rdata == $past(bus_wdata, 2));

  assert_slot_route_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_devno == 5'h11) |-> (irq_line == irq_pin + 2'd1 && !irq_bad_dev));

  assert_bad_device_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_devno != 5'h11 && irq_devno != 5'h12) |-> (irq_bad_dev && irq_line == 2'd0));

endmodule

bind pcihb_regbank pcihb_regbank_chk u_chk (.*);

// File: tb/pcihb_regbank_bench.sv
`timescale 1ns/1ps
module pcihb_regbank_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, cfg_rdata = '0;
  logic [31:0] bus_rdata, cfg_wdata;
  logic        bus_rvalid, cfg_addr_wr, cfg_addr_rd, cfg_data_wr, cfg_data_rd;
  logic [4:0]  irq_devno = '0;
  logic [1:0]  irq_pin = '0;
  logic [1:0]  irq_line;
  logic        irq_bad_dev;

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  pcihb_regbank u_pcihb_regbank (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  function automatic logic [31:0] pat(input logic [11:0] a);
    return {8'hA5, a, ~a};
  endfunction

  function automatic logic [31:0] rev(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  // mapped addresses: 0..15 outbound, 16..27 inbound, 28 timer
  function automatic logic [11:0] mapped(input int k);
    int ooff[4] = '{0, 4, 8, 'h10};
    int ioff[4] = '{0, 8, 'hC, 'h10};
    if (k < 16) return 12'('hC20 + 'h20*(k/4) + ooff[k%4]);
    if (k < 28) return 12'('hDA0 + 'h20*((k-16)/4) + ioff[(k-16)%4]);
    return 12'hE20;
  endfunction

  function automatic string req_of(input int k);
    if (k < 16) return "R2";
    if (k < 28) return "R4";
    return "R5";
  endfunction

  task automatic do_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_rd = 1'b0; bus_addr = a; bus_wdata = d;
  endtask

  task automatic do_rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  // monitor: sampled 1 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n) begin
        chk(bus_rvalid == bus_rd, "R7 rvalid timing", 32'(bus_rvalid), 32'(bus_rd));
        if (bus_rvalid) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R7 unexpected read data", bus_rdata, 32'd0);
          end else begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(bus_rdata == e, t, bus_rdata, e);
          end
        end
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    chk(1'b0, "watchdog", 32'd0, 32'd1);
    report();
  end

  initial begin
    logic [11:0] holes[14];
    holes = '{12'hC2C, 12'hC4C, 12'hDA4, 12'hDE4, 12'hCA0, 12'hCC0, 12'hD80,
              12'hE24, 12'hE40, 12'hC00, 12'h008, 12'hC34, 12'hDBC, 12'hFFC};
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int k = 0; k < 29; k++) do_rd(mapped(k), 32'd0, "R1 reset value");
    idle();

    // R2 R4 R5: fill every register, read back
    for (int k = 0; k < 29; k++) do_wr(mapped(k), pat(mapped(k)));
    for (int k = 0; k < 29; k++) do_rd(mapped(k), pat(mapped(k)), req_of(k));
    idle();

    // R3 R6: writes to holes and unmapped offsets, then read them
    for (int k = 0; k < 14; k++) do_wr(holes[k], 32'hDEAD_BEEF);
    for (int k = 0; k < 14; k++) do_rd(holes[k], 32'd0, (k < 4) ? "R3 hole" : "R6 unmapped");
    for (int k = 0; k < 29; k++) do_rd(mapped(k), pat(mapped(k)), "R6 no side effect");
    idle();

    // R7 R5: write then read in the next cycle
    do_wr(12'hE20, 32'hFFFF_0001);
    do_rd(12'hE20, 32'hFFFF_0001, "R7 read after write");
    do_wr(12'hC90, 32'h1234_5678);
    do_rd(12'hC80, pat(12'hC80), "R2 attr apart from xlat");
    do_rd(12'hC90, 32'h1234_5678, "R7 attr readback");
    idle();

    // R8: config address port, byte reversed
    do_wr(12'h000, 32'h1122_3344);
    #1;
    chk(cfg_addr_wr && !cfg_data_wr, "R8 addr write strobe", {cfg_addr_wr, cfg_data_wr}, 32'd2);
    chk(cfg_wdata == 32'h4433_2211, "R8 write data", cfg_wdata, 32'h4433_2211);
    cfg_rdata = 32'hAABB_CCDD;
    do_rd(12'h000, 32'hDDCC_BBAA, "R8 read data");
    #1;
    chk(cfg_addr_rd && !cfg_data_rd, "R8 addr read strobe", {cfg_addr_rd, cfg_data_rd}, 32'd2);

    // R9: config data port, unchanged
    do_wr(12'h004, 32'hCAFE_F00D);
    #1;
    chk(cfg_data_wr && !cfg_addr_wr, "R9 data write strobe", {cfg_data_wr, cfg_addr_wr}, 32'd2);
    chk(cfg_wdata == 32'hCAFE_F00D, "R9 write data", cfg_wdata, 32'hCAFE_F00D);
    cfg_rdata = 32'h0102_0304;
    do_rd(12'h004, 32'h0102_0304, "R9 read data");
    #1;
    chk(cfg_data_rd && !cfg_addr_rd, "R9 data read strobe", {cfg_data_rd, cfg_addr_rd}, 32'd2);
    do_wr(12'h008, 32'h5555_5555);
    #1;
    chk({cfg_addr_wr, cfg_addr_rd, cfg_data_wr, cfg_data_rd} == 4'd0, "R9 no strobe at 0x008",
        32'({cfg_addr_wr, cfg_addr_rd, cfg_data_wr, cfg_data_rd}), 32'd0);
    idle();

    // R10 R11: interrupt routing
    for (int d = 0; d < 32; d++) begin
      for (int p = 0; p < 4; p++) begin
        logic [1:0] el;
        logic       eb;
        irq_devno = 5'(d);
        irq_pin   = 2'(p);
        #1;
        if (d == 'h11 || d == 'h12) begin
          el = 2'((p + d - 'h10) % 4);
          eb = 1'b0;
          chk(irq_line == el && irq_bad_dev == eb, "R10 slot routing",
              {irq_bad_dev, irq_line}, {eb, el});
        end else begin
          el = 2'd0;
          eb = 1'b1;
          chk(irq_line == el && irq_bad_dev == eb, "R11 unknown device",
              {irq_bad_dev, irq_line}, {eb, el});
        end
      end
    end

    repeat (4) idle();
    chk(exp_q.size() == 0, "R7 all reads answered", exp_q.size(), 32'd0);
    report();
  end

endmodule